// File: doc/BRIEF.md
# Serial Remote-Control Key Decoder

This block listens to a single asynchronous serial line from a wired remote control and turns each received byte into a key event. A byte is framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity bit. The bit time is set at run time by a divisor input: one bit lasts 32 × (divisor + 1) system clocks. A 12 MHz clock with a 9600 baud line gives a divisor of 38.

Each byte that arrives intact is looked up against six known codes: volume down, volume up, next, previous, stop and play. A recognised code is put on the key bus, together with one of two strobes. The press strobe marks a new key press. The repeat strobe marks a key that is still being held. The choice depends on how many clocks have passed since the previous recognised code and whether that code was the same one. The held-key window is a parameter in system clocks. With a 12 MHz clock its default is half a second.

A byte whose stop bit samples low raises a one-cycle framing error flag. That byte is then discarded.

Top module: `rkd_remote_decoder`

## Requirements
- R1: After reset, key_o is 0 and press_o, repeat_o and frame_err_o are all low.
- R2: One bit lasts 32 × (divisor_i + 1) clocks. A frame is a low start bit, eight data bits least significant bit first, and a high stop bit. Each data bit is sampled at the centre of its bit time, and bytes decode correctly for any divisor.
- R3: A start bit is accepted only if the line is still low half a bit time after the falling edge. A shorter low pulse produces no strobe and no framing error.
- R4: Byte codes map onto key_o values as follows:
  - 0xE0 gives volume down (1).
  - 0xD0 gives volume up (2).
  - 0xC8 gives next (3).
  - 0xC4 gives previous (4).
  - 0xC2 gives stop (5).
  - 0xC1 gives play (6).
- R5: Any other byte value produces no strobe and leaves key_o and the held-key history unchanged.
- R6: The first recognised code after reset, or a code different from the previous recognised one, pulses press_o.
- R7: A recognised code equal to the previous one and arriving less than REPEAT_WIN clocks after it pulses repeat_o.
- R8: A recognised code equal to the previous one and arriving REPEAT_WIN or more clocks after it pulses press_o.
- R9: A stop bit sampled low has the following effects:
  - frame_err_o pulses for exactly one cycle.
  - No strobe is produced.
  - The held-key history is left untouched.
  - The receiver waits for the line to return high before it looks for a new start bit.
- R10: press_o and repeat_o are never high together. Each recognised byte gives exactly one single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line from the remote; idles high |
| divisor_i | input | DIV_W | Bit-rate divisor; one bit lasts 32 × (divisor_i + 1) clocks |
| key_o | output | 3 | Last recognised key: 0 none, 1 to 6 per R4 |
| press_o | output | 1 | One-cycle strobe for a new key press |
| repeat_o | output | 1 | One-cycle strobe for a held key |
| frame_err_o | output | 1 | One-cycle flag for a frame with a low stop bit |

## Verification
A strobe or error flag follows the centre of the stop bit by four clocks. Two of those clocks are the input synchroniser, one is the receiver state register and one is the key-history register. That point always falls well before the end of the stop bit. So the bench counts strobe and error cycles at the falling clock edge and compares the counts, and key_o, once the full stop bit has been driven. A glitch check waits two bit times before it looks. The expected press-or-repeat decision comes from the difference between frame start cycles. Every frame has the same fixed start-to-strobe offset, so this difference equals the strobe-to-strobe gap. Idle gaps are kept hundreds of clocks away from the window edge.

// File: rtl/rkd_pkg.sv
package rkd_pkg;

    localparam int OVERSAMPLE = 32;
    localparam int PH_W       = $clog2(OVERSAMPLE);
    localparam int HALF_PH    = OVERSAMPLE / 2;

    typedef enum logic [2:0] {
        KEY_NONE   = 3'd0,
        KEY_VOL_DN = 3'd1,
        KEY_VOL_UP = 3'd2,
        KEY_NEXT   = 3'd3,
        KEY_PREV   = 3'd4,
        KEY_STOP   = 3'd5,
        KEY_PLAY   = 3'd6
    } key_e;

    localparam logic [7:0] CODE_VOL_DN = 8'hE0;
    localparam logic [7:0] CODE_VOL_UP = 8'hD0;
    localparam logic [7:0] CODE_NEXT   = 8'hC8;
    localparam logic [7:0] CODE_PREV   = 8'hC4;
    localparam logic [7:0] CODE_STOP   = 8'hC2;
    localparam logic [7:0] CODE_PLAY   = 8'hC1;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

endpackage

// File: rtl/rkd_baud.sv
module rkd_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == divisor_i);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && run_i && divisor_i != '0 && $stable(divisor_i)) |=> !tick_o); // R2

endmodule

// File: rtl/rkd_rx.sv
module rkd_rx
    import rkd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic [7:0]       byte_o,
    output logic             byte_valid_o,
    output logic             frame_err_o
);

    typedef struct packed {
        rx_state_e        state;
        logic [PH_W-1:0]  ph;
        logic [2:0]       bitn;
        logic [7:0]       shreg;
        logic             valid;
        logic             err;
        logic             meta;
        logic             sync;
    } rx_s;

    rx_s  d, q;
    logic tick;
    logic run;

    assign run = (q.state == RX_START) || (q.state == RX_DATA) || (q.state == RX_STOP);

    rkd_baud #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .divisor_i (divisor_i),
        .tick_o    (tick)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.err   = 1'b0;
        d.meta  = rx_i;
        d.sync  = q.meta;
        case (q.state)
            RX_IDLE: begin
                if (!q.sync) begin
                    d.state = RX_START;
                    d.ph    = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.ph == PH_W'(HALF_PH - 1)) begin
                        d.ph   = '0;
                        d.bitn = '0;
                        d.state = q.sync ? RX_IDLE : RX_DATA;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (q.ph == PH_W'(OVERSAMPLE - 1)) begin
                        d.ph    = '0;
                        d.shreg = {q.sync, q.shreg[7:1]};
                        if (q.bitn == 3'd7) begin
                            d.state = RX_STOP;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (q.ph == PH_W'(OVERSAMPLE - 1)) begin
                        d.ph = '0;
                        if (q.sync) begin
                            d.valid = 1'b1;
                            d.state = RX_IDLE;
                        end else begin
                            d.err   = 1'b1;
                            d.state = RX_BREAK;
                        end
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
            end
            RX_BREAK: begin
                if (q.sync) begin
                    d.state = RX_IDLE;
                end
            end
            default: d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: RX_IDLE, ph: '0, bitn: '0, shreg: '0,
                   valid: 1'b0, err: 1'b0, meta: 1'b1, sync: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign byte_o       = q.shreg;
    assign byte_valid_o = q.valid;
    assign frame_err_o  = q.err;

    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.valid && q.err)); // R9
    AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RX_BREAK && !q.sync) |=> (q.state == RX_BREAK)); // R9
    AST_GLITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RX_START) |=> !(q.valid || q.err)); // R3

endmodule

// File: rtl/rkd_keymap.sv
module rkd_keymap
    import rkd_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic       valid_i,
    output logic [2:0] key_o,
    output logic       hit_o
);

    key_e key;

    always_comb begin
        case (byte_i)
            CODE_VOL_DN: key = KEY_VOL_DN;
            CODE_VOL_UP: key = KEY_VOL_UP;
            CODE_NEXT:   key = KEY_NEXT;
            CODE_PREV:   key = KEY_PREV;
            CODE_STOP:   key = KEY_STOP;
            CODE_PLAY:   key = KEY_PLAY;
            default:     key = KEY_NONE;
        endcase
    end

    assign key_o = key;
    assign hit_o = valid_i && (key != KEY_NONE);

endmodule

// File: rtl/rkd_hold.sv
module rkd_hold #(
    parameter int REPEAT_WIN = 6_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic [2:0] key_i,
    input  logic       err_i,
    output logic [2:0] key_o,
    output logic       press_o,
    output logic       repeat_o,
    output logic       err_o
);

    localparam int GAP_W = $clog2(REPEAT_WIN + 1);
    localparam logic [GAP_W-1:0] WIN = GAP_W'(REPEAT_WIN);

    typedef struct packed {
        logic [2:0]       key;
        logic             seen;
        logic [GAP_W-1:0] gap;
        logic             press;
        logic             rep;
        logic             err;
    } hold_s;

    hold_s d, q;

    always_comb begin
        d       = q;
        d.press = 1'b0;
        d.rep   = 1'b0;
        d.err   = err_i;
        if (q.gap < WIN) begin
            d.gap = q.gap + 1'b1;
        end
        if (hit_i) begin
            if (q.seen && (key_i == q.key) && (q.gap < WIN)) begin
                d.rep = 1'b1;
            end else begin
                d.press = 1'b1;
            end
            d.key  = key_i;
            d.seen = 1'b1;
            d.gap  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign key_o    = q.key;
    assign press_o  = q.press;
    assign repeat_o = q.rep;
    assign err_o    = q.err;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.press && q.rep)); // R10
    AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.press |=> !q.press); // R10
    AST_REPEAT_SAME_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        q.rep |-> (q.key == $past(q.key))); // R7
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> !(q.press || q.rep)); // R9
    AST_STROBE_HAS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.press || q.rep) |-> (q.key != 3'd0)); // R4

endmodule

// File: rtl/rkd_remote_decoder.sv
module rkd_remote_decoder #(
    parameter int DIV_W      = 8,
    parameter int REPEAT_WIN = 6_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic [2:0]       key_o,
    output logic             press_o,
    output logic             repeat_o,
    output logic             frame_err_o
);

    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_err;
    logic [2:0] map_key;
    logic       map_hit;

    rkd_rx #(.DIV_W(DIV_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_i         (rx_i),
        .divisor_i    (divisor_i),
        .byte_o       (rx_byte),
        .byte_valid_o (rx_valid),
        .frame_err_o  (rx_err)
    );

    rkd_keymap u_map (
        .byte_i  (rx_byte),
        .valid_i (rx_valid),
        .key_o   (map_key),
        .hit_o   (map_hit)
    );

    rkd_hold #(.REPEAT_WIN(REPEAT_WIN)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (map_hit),
        .key_i    (map_key),
        .err_i    (rx_err),
        .key_o    (key_o),
        .press_o  (press_o),
        .repeat_o (repeat_o),
        .err_o    (frame_err_o)
    );

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o); // R9

endmodule

// File: tb/rkd_remote_decoder_test.sv
`timescale 1ns/1ps
module rkd_remote_decoder_test;

    localparam int WIN = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] divisor = 8'd1;
    logic [2:0] key_o;
    logic       press_o, repeat_o, frame_err_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int press_n = 0, rep_n = 0, err_n = 0;
    bit done = 0;

    bit h_seen = 0;
    int h_key = 0;
    int h_start = 0;
    int prev_code = -1;

    always #2.5 clk = ~clk;

    rkd_remote_decoder #(.DIV_W(8), .REPEAT_WIN(WIN)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_i        (rx),
        .divisor_i   (divisor),
        .key_o       (key_o),
        .press_o     (press_o),
        .repeat_o    (repeat_o),
        .frame_err_o (frame_err_o)
    );

    always @(negedge clk) begin
        cyc++;
        if (press_o) press_n++;
        if (repeat_o) rep_n++;
        if (frame_err_o) err_n++;
    end

    function automatic int exp_key(input logic [7:0] b);
        case (b)
            8'hE0: return 1;
            8'hD0: return 2;
            8'hC8: return 3;
            8'hC4: return 4;
            8'hC2: return 5;
            8'hC1: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] code_of(input int k);
        case (k)
            1: return 8'hE0;
            2: return 8'hD0;
            3: return 8'hC8;
            4: return 8'hC4;
            5: return 8'hC2;
            default: return 8'hC1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        rx = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Sends a frame; model-checks strobes and key after the stop bit.
    task automatic send(input logic [7:0] b, input bit stop_ok, input int low_after, input string req);
        int bt, fs, p0, r0, e0, k, ek, exp_p, exp_r;
        bt = 32 * (int'(divisor) + 1);
        p0 = press_n; r0 = rep_n; e0 = err_n;
        fs = cyc;
        hold_line(1'b0, bt);
        for (int i = 0; i < 8; i++) hold_line(b[i], bt);
        hold_line(stop_ok, bt);
        if (!stop_ok) begin
            hold_line(1'b0, low_after);
            check(err_n - e0 == 1, {req, " frame error pulse"}, err_n - e0, 1);
            check((press_n - p0) + (rep_n - r0) == 0, {req, " no strobe on error"}, (press_n - p0) + (rep_n - r0), 0);
            check(int'(key_o) == h_key, {req, " key kept on error"}, key_o, h_key);
            rx = 1'b1;
            return;
        end
        k = exp_key(b);
        exp_p = 0; exp_r = 0;
        if (k != 0) begin
            if (h_seen && h_key == k && (fs - h_start) < WIN) exp_r = 1;
            else exp_p = 1;
            h_seen = 1; h_key = k; h_start = fs;
        end
        ek = h_key;
        check(press_n - p0 == exp_p, {req, " press count"}, press_n - p0, exp_p);
        check(rep_n - r0 == exp_r, {req, " repeat count"}, rep_n - r0, exp_r);
        check(err_n == e0, {req, " no error"}, err_n - e0, 0);
        check(int'(key_o) == ek, {req, " key value"}, key_o, ek);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(key_o == 3'd0, "R1 key", key_o, 0);
        check(!press_o && !repeat_o, "R1 strobes", press_o + repeat_o, 0);
        check(!frame_err_o, "R1 frame_err", frame_err_o, 0);
        rst_n = 1'b1;
        idle(20);

        // R4 and R6: every code once, different codes each a press
        for (int k = 1; k <= 6; k++) begin
            send(code_of(k), 1'b1, 0, "R4 R6");
            idle(50);
        end

        // R7 repeat inside window, R8 press after window
        send(8'hC1, 1'b1, 0, "R6");
        idle(100);
        send(8'hC1, 1'b1, 0, "R7");
        idle(2600);
        send(8'hC1, 1'b1, 0, "R8");
        idle(100);

        // R5 unrecognised byte ignored; history kept so next PLAY repeats
        send(8'h55, 1'b1, 0, "R5");
        idle(50);
        send(8'hC1, 1'b1, 0, "R5 R7");
        idle(50);

        // R3 short glitch ignored
        begin
            int p0, r0, e0;
            p0 = press_n; r0 = rep_n; e0 = err_n;
            hold_line(1'b0, 16);
            idle(128);
            check(press_n == p0 && rep_n == r0, "R3 glitch no strobe", press_n - p0 + rep_n - r0, 0);
            check(err_n == e0, "R3 glitch no error", err_n - e0, 0);
        end
        idle(50);

        // R9 framing error, line stays low, then history intact
        send(8'hC1, 1'b1, 0, "R9");
        idle(50);
        send(8'hC1, 1'b0, 192, "R9");
        idle(50);
        send(8'hC1, 1'b1, 0, "R9 R7");
        idle(2600);

        // R2 other divisors
        divisor = 8'd0;
        idle(2600);
        send(8'hC8, 1'b1, 0, "R2 div0");
        idle(100);
        send(8'hC8, 1'b1, 0, "R2 div0 R7");
        divisor = 8'd3;
        idle(2600);
        send(8'hC4, 1'b1, 0, "R2 div3");
        idle(100);
        send(8'hC2, 1'b1, 0, "R2 div3 R6");
        divisor = 8'd1;
        idle(2600);

        // Random mix (R6 R7 R8 R10)
        prev_code = -1;
        for (int n = 0; n < 40; n++) begin
            int pick, k, gap;
            logic [7:0] b;
            bit was_unrec;
            pick = $urandom_range(9, 0);
            was_unrec = (prev_code == 0);
            if (pick == 9 && !was_unrec) begin
                b = 8'h55;
                k = 0;
            end else if (pick < 4 && h_seen) begin
                k = h_key;
                b = code_of(k);
            end else begin
                k = $urandom_range(6, 1);
                b = code_of(k);
            end
            send(b, 1'b1, 0, "R10 random");
            prev_code = k;
            if ($urandom_range(1, 0) == 1) gap = $urandom_range(300, 20);
            else gap = $urandom_range(3200, 2600);
            idle(gap);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule